// File: doc/BRIEF.md
# Comparator Event Control Logic

This block is the digital controller that sits beside one analog comparator. It takes the raw compare bit from the analog cell (1 when the positive input is above the negative input) and brings it into the clock domain through a synchronizer. It then applies an enable and an optional inversion, and can present the result on an external pin.

A 16-bit control/status word is written through a write strobe and data bus and is always readable. That word also carries the reference-select and channel-select settings, which are only stored here and passed out to the analog side. An edge selector watches the polarity-adjusted output and looks for rising edges, falling edges or any change. When the selected edge occurs, a sticky event flag is set and a single-cycle trigger pulse is sent. While the flag is set, no further trigger can occur until software writes the flag back to zero.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset every register bit reads 0, and `pin_o`, `pin_oe_o` and `trig_o` are 0.
- R2: The word reads back as {enable[15], pin enable[14], invert[13], 0[12:10], event flag[9], status[8], edge select[7:6], 0[5], reference select[4], 0[3:2], channel[1:0]`}`. Bits 12:10, 5 and 3:2 always read 0, and a write of 16'hFFFF reads back as 16'hE3D3 while the synchronized compare bit is 0.
- R3: With enable (bit 15) at 0, the status bit reads 0 and no trigger or flag set occurs, whatever the compare input does.
- R4: With enable at 1, the status bit equals the compare bit XOR invert (bit 13). A change at `cmp_raw_i` reaches the status bit after two clock edges.
- R5: With pin enable (bit 14) at 1, `pin_oe_o` is 1 and `pin_o` follows the status bit. With pin enable at 0, both are 0.
- R6: Edge select 00 produces no events. Edge select 11 produces an event on every change of the status bit.
- R7: Edge select 01 produces an event on a 0-to-1 change of the status bit when invert is 0, and on a 1-to-0 change when invert is 1.
- R8: Edge select 10 produces an event on a 1-to-0 change of the status bit when invert is 0, and on a 0-to-1 change when invert is 1.
- R9: An event sets the flag and raises `trig_o` for exactly one cycle, one clock edge after the status bit changes. While the flag is 1, status changes produce no trigger.
- R10: A write with bit 9 at 0 clears the flag. If an event and such a write fall on the same clock edge, the flag ends up set.
- R11: Setting enable from 0 to 1 never produces an event by itself; an event needs enable on in both the current and the previous cycle.
- R12: Reference select (bit 4) drives `ref_sel_o`, and channel (bits 1:0) drives `chan_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_raw_i | input | 1 | Asynchronous compare bit from the analog cell |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| pin_o | output | 1 | Value for the external output pin |
| pin_oe_o | output | 1 | Output enable for the external pin |
| trig_o | output | 1 | One-cycle trigger/interrupt pulse |
| ref_sel_o | output | 1 | Stored reference select |
| chan_sel_o | output | 2 | Stored channel select |

## Verification
The assertions assume that the compare input reaches the logic only through the synchronizer, and that software is the only source of flag writes. The stimulus drives every input on the falling clock edge. It leaves the compare bit stable for at least four cycles before each measured edge, so the history of the status bit is known. Each table case rewrites the configuration and clears the flag after the input settles. As a result, the only edge a case measures is the one it applies on purpose, and polarity is never changed while an edge is under test.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;
  localparam int unsigned CSR_W      = 16;
  localparam int unsigned CH_W       = 2;
  localparam int unsigned B_EN       = 15;
  localparam int unsigned B_OE       = 14;
  localparam int unsigned B_INV      = 13;
  localparam int unsigned B_FLAG     = 9;
  localparam int unsigned B_STAT     = 8;
  localparam int unsigned B_SEL_LO   = 6;
  localparam int unsigned B_REF      = 4;
  localparam int unsigned B_CH_LO    = 0;
  localparam logic [CSR_W-1:0] RSVD_MASK = 16'h1C2C;

  typedef enum logic [1:0] {
    EV_OFF = 2'b00,
    EV_FWD = 2'b01,
    EV_REV = 2'b10,
    EV_ANY = 2'b11
  } ev_sel_e;

  typedef struct packed {
    logic            en;
    logic            oe;
    logic            inv;
    ev_sel_e         sel;
    logic            refsel;
    logic [CH_W-1:0] chan;
  } cfg_t;

  function automatic cfg_t csr_decode(input logic [CSR_W-1:0] w);
    cfg_t c;
    c.en     = w[B_EN];
    c.oe     = w[B_OE];
    c.inv    = w[B_INV];
    c.sel    = ev_sel_e'(w[B_SEL_LO+1:B_SEL_LO]);
    c.refsel = w[B_REF];
    c.chan   = w[B_CH_LO+CH_W-1:B_CH_LO];
    return c;
  endfunction
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = d_i;
    end else begin : g_many
      assign chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_csr.sv
module cmp_csr
  import cmp_evt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  cfg_t             wcfg_i,
  input  logic             stat_i,
  input  logic             flag_i,
  output cfg_t             cfg_o,
  output logic [CSR_W-1:0] rdata_o
);
  cfg_t cfg_q;
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) cfg_d = wcfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  always_comb begin
    rdata_o                           = '0;
    rdata_o[B_EN]                     = cfg_q.en;
    rdata_o[B_OE]                     = cfg_q.oe;
    rdata_o[B_INV]                    = cfg_q.inv;
    rdata_o[B_FLAG]                   = flag_i;
    rdata_o[B_STAT]                   = stat_i;
    rdata_o[B_SEL_LO+1:B_SEL_LO]      = cfg_q.sel;
    rdata_o[B_REF]                    = cfg_q.refsel;
    rdata_o[B_CH_LO+CH_W-1:B_CH_LO]   = cfg_q.chan;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cmp_evt_unit.sv
module cmp_evt_unit
  import cmp_evt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  logic    inv_i,
  input  ev_sel_e sel_i,
  input  logic    cmp_s_i,
  input  logic    we_i,
  input  logic    wflag_i,
  output logic    stat_o,
  output logic    flag_o,
  output logic    trig_o
);
  logic stat_c, stat_q, en_q, flag_q, trig_q;
  logic flag_d, trig_d, rise, fall, match, hit;

  assign stat_c = en_i & (cmp_s_i ^ inv_i);
  assign rise   = stat_c & ~stat_q;
  assign fall   = ~stat_c & stat_q;

  always_comb begin
    case (sel_i)
      EV_FWD:  match = inv_i ? fall : rise;
      EV_REV:  match = inv_i ? rise : fall;
      EV_ANY:  match = rise | fall;
      default: match = 1'b0;
    endcase
  end

  assign hit = en_i & en_q & ~flag_q & match;

  always_comb begin
    flag_d = flag_q;
    if (we_i) flag_d = wflag_i;
    if (hit)  flag_d = 1'b1;
    trig_d = hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      stat_q <= stat_c;
      en_q   <= en_i;
      flag_q <= flag_d;
      trig_q <= trig_d;
    end
  end

  assign stat_o = stat_c;
  assign flag_o = flag_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/cmp_evt_ctrl.sv
module cmp_evt_ctrl
  import cmp_evt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw_i,
  input  logic             reg_we_i,
  input  logic [CSR_W-1:0] reg_wdata_i,
  output logic [CSR_W-1:0] reg_rdata_o,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             trig_o,
  output logic             ref_sel_o,
  output logic [CH_W-1:0]  chan_sel_o
);
  logic rst_int_n, cmp_s, stat, flag;
  cfg_t cfg;
  cfg_t wcfg;
  logic unused_wbits;

  assign wcfg         = csr_decode(reg_wdata_i);
  assign unused_wbits = ^(reg_wdata_i & (RSVD_MASK | (CSR_W'(1) << B_STAT)));

  cmp_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i(clk), .arst_ni(rst_n), .d_i(1'b1), .q_o(rst_int_n)
  );

  cmp_sync #(.STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i(clk), .arst_ni(rst_int_n), .d_i(cmp_raw_i), .q_o(cmp_s)
  );

  cmp_csr u_csr (
    .clk_i(clk), .rst_ni(rst_int_n), .we_i(reg_we_i), .wcfg_i(wcfg),
    .stat_i(stat), .flag_i(flag), .cfg_o(cfg), .rdata_o(reg_rdata_o)
  );

  cmp_evt_unit u_evt (
    .clk_i(clk), .rst_ni(rst_int_n), .en_i(cfg.en), .inv_i(cfg.inv),
    .sel_i(cfg.sel), .cmp_s_i(cmp_s), .we_i(reg_we_i),
    .wflag_i(reg_wdata_i[B_FLAG]), .stat_o(stat), .flag_o(flag),
    .trig_o(trig_o)
  );

  assign pin_oe_o   = cfg.oe;
  assign pin_o      = cfg.oe & stat;
  assign ref_sel_o  = cfg.refsel;
  assign chan_sel_o = cfg.chan;
endmodule

// File: rtl/cmp_evt_ctrl_chk.sv
module cmp_evt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input logic [15:0] rdata,
  input logic        pin_o,
  input logic        pin_oe_o,
  input logic        trig_o
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & 16'h1C2C) == 16'h0000);

  assert_off_no_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[15] |=> !trig_o);

  assert_off_stat_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[15] |-> !rdata[8]);

  assert_pin_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe_o |-> !pin_o);

  assert_trig_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  assert_trig_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> rdata[9]);

  assert_flag_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[9] |=> !trig_o);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[9] && !we) |=> rdata[9]);
endmodule

bind cmp_evt_ctrl cmp_evt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we(reg_we_i), .rdata(reg_rdata_o),
  .pin_o(pin_o), .pin_oe_o(pin_oe_o), .trig_o(trig_o)
);

// File: tb/tb_cmp_evt_ctrl.sv
module tb_cmp_evt_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, raw, we;
  logic [15:0] wdata, rdata;
  logic        pin, pin_oe, trig, refsel;
  logic [1:0]  chan;
  int n_chk, n_err, trig_cnt;
  bit done;

  cmp_evt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw_i(raw), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pin_o(pin),
    .pin_oe_o(pin_oe), .trig_o(trig), .ref_sel_o(refsel), .chan_sel_o(chan)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && trig === 1'b1) trig_cnt++;

  // {invert, edge select[1:0], raw before, raw after, expected status, expected event}
  localparam logic [6:0] VEC [0:13] = '{
    7'b0_01_01_11, 7'b0_01_10_00, 7'b0_10_10_01, 7'b0_10_01_10,
    7'b1_01_10_10, 7'b1_01_01_01, 7'b1_10_10_11, 7'b1_10_01_00,
    7'b0_11_01_11, 7'b0_11_10_01, 7'b1_11_01_01, 7'b0_00_01_10,
    7'b1_00_10_10, 7'b0_01_11_10
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wdata = d; we = 1'b1;
    tick(1);
    we = 1'b0;
  endtask

  function automatic logic [15:0] cw(input logic en, input logic oe, input logic inv,
                                     input logic [1:0] sel, input logic f);
    return {en, oe, inv, 3'b000, f, 1'b0, sel, 6'b000000};
  endfunction

  initial begin
    int c0;
    n_chk = 0; n_err = 0; trig_cnt = 0; done = 0;
    rst_n = 1'b0; raw = 1'b0; we = 1'b0; wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    chk("R1 rdata", rdata, 16'h0000);
    chk("R1 pins", {13'd0, pin, pin_oe, trig}, 16'h0000);

    wr(16'hFFFF);
    chk("R2 readback", rdata, 16'hE3D3);
    wr(16'h0000);
    chk("R2 cleared", rdata, 16'h0000);

    wr(16'h0012);
    chk("R12 exports", {13'd0, refsel, chan}, 16'h0006);
    chk("R12 readback", rdata, 16'h0012);

    wr(cw(0, 0, 0, 2'b11, 0));
    c0 = trig_cnt;
    raw = 1'b1; tick(4);
    chk("R3 status off", {15'd0, rdata[8]}, 16'h0000);
    raw = 1'b0; tick(4); raw = 1'b1; tick(4);
    chk("R3 no trig", 16'(trig_cnt - c0), 16'h0000);
    chk("R3 no flag", {15'd0, rdata[9]}, 16'h0000);

    wr(cw(1, 0, 0, 2'b00, 0));
    raw = 1'b0; tick(4);
    raw = 1'b1; tick(1);
    chk("R4 one stage", {15'd0, rdata[8]}, 16'h0000);
    tick(1);
    chk("R4 two stages", {15'd0, rdata[8]}, 16'h0001);
    wr(cw(1, 0, 1, 2'b00, 0));
    chk("R4 inverted", {15'd0, rdata[8]}, 16'h0000);

    wr(cw(1, 1, 0, 2'b00, 0));
    chk("R5 pin on", {14'd0, pin, pin_oe}, 16'h0003);
    wr(cw(1, 0, 0, 2'b00, 0));
    chk("R5 pin off", {14'd0, pin, pin_oe}, 16'h0000);

    for (int i = 0; i < 14; i++) begin
      logic [6:0] v;
      string tag;
      v = VEC[i];
      tag = (v[5:4] == 2'b01) ? "R7" : (v[5:4] == 2'b10) ? "R8" : "R6";
      raw = v[3];
      wr(cw(1, 0, v[6], v[5:4], 0));
      tick(4);
      wr(cw(1, 0, v[6], v[5:4], 0));
      tick(1);
      c0 = trig_cnt;
      raw = v[2];
      tick(2);
      chk($sformatf("%s case %0d status", tag, i), {15'd0, rdata[8]}, {15'd0, v[1]});
      tick(1);
      chk($sformatf("%s case %0d trig", tag, i), {14'd0, trig, rdata[9]}, {14'd0, v[0], v[0]});
      tick(2);
      chk($sformatf("R9 case %0d pulse count", i), 16'(trig_cnt - c0), {15'd0, v[0]});
    end

    raw = 1'b0;
    wr(cw(1, 0, 0, 2'b11, 0));
    tick(4);
    wr(cw(1, 0, 0, 2'b11, 0));
    tick(1);
    c0 = trig_cnt;
    raw = 1'b1; tick(3);
    chk("R9 first event", {14'd0, trig, rdata[9]}, 16'h0003);
    raw = 1'b0; tick(4); raw = 1'b1; tick(4);
    chk("R9 blocked", 16'(trig_cnt - c0), 16'h0001);
    wr(cw(1, 0, 0, 2'b11, 0));
    chk("R10 clear", {15'd0, rdata[9]}, 16'h0000);
    raw = 1'b0; tick(2);
    wr(cw(1, 0, 0, 2'b11, 0));
    chk("R10 set wins", {15'd0, rdata[9]}, 16'h0001);

    wr(cw(0, 0, 0, 2'b11, 0));
    raw = 1'b1; tick(4);
    c0 = trig_cnt;
    wr(cw(1, 0, 0, 2'b11, 0));
    tick(4);
    chk("R11 no event", {15'd0, rdata[9]}, 16'h0000);
    chk("R11 no trig", 16'(trig_cnt - c0), 16'h0000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule